// File: doc/BRIEF.md
# Click-Free Settings Commit Gate

This block sits between a serial settings receiver and the audio datapath controls. Each newly received settings word is held in a single-entry pending slot. It does not take effect at once. It is copied into the active settings register only at a moment when a level change cannot be heard.

That moment is one of three events:
- the next zero crossing of the audio input;
- any cycle in which the input is flagged as silent;
- the expiry of a programmable timeout. The timeout is counted in clock cycles and starts at the falling edge of the strobe that closes a serial frame.

A separate supply-low input forces the output mute flag, whatever the settings are.

New words arrive on a valid/ready stream. Ready is always high, so the block never applies back-pressure. A word offered while another is still pending overwrites it and cancels the running timeout. Every commit produces a one-cycle `applied` pulse in the same cycle that `active_word` takes its new value.

Top module: `zcd_commit_gate`

## Requirements
- R1: During and right after reset, `active_word` equals the power-on word (parameter `RESET_WORD`), `applied` is 0, `mute` is 0 and nothing is pending.
- R2: `upd_ready` is 1 in every cycle after reset, and each cycle with `upd_valid` high stores `upd_word` as the pending word.
- R3: With a word pending, a clock edge that samples `zc_pulse` high commits it: after that edge `active_word` holds the pending word and `applied` is 1.
- R4: With a word pending, a clock edge that samples `no_signal` high commits it in the same way, with no zero crossing needed.
- R5: If `ce_fall` is sampled at edge E while a word is pending, and neither a trigger nor a new word arrives, the word is committed at edge E+T+1. Here T is the `tmo_cycles` value sampled at E.
- R6: While no trigger occurs, `active_word` does not change and `applied` stays 0.
- R7: A new word accepted while another is pending replaces it and cancels the timeout. The timeout runs again only after a later `ce_fall`.
- R8: When `upd_valid` and a trigger are sampled at the same edge, the word is loaded and no commit happens at that edge.
- R9: `applied` is never high for two cycles in a row. A trigger with nothing pending leaves `applied` at 0 and `active_word` unchanged.
- R10: `mute` equals `supply_low` delayed by one clock edge. Muting has no effect on `active_word` or on commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | A new settings word is offered |
| upd_ready | output | 1 | Always 1; no back-pressure |
| upd_word | input | SET_W | Offered settings word |
| zc_pulse | input | 1 | One-cycle zero-crossing event |
| no_signal | input | 1 | Input is silent (level flag) |
| ce_fall | input | 1 | One-cycle frame-strobe falling-edge event |
| tmo_cycles | input | TMR_W | Timeout length in cycles |
| supply_low | input | 1 | Supply below the safe threshold |
| active_word | output | SET_W | Settings currently in force |
| applied | output | 1 | One-cycle pulse on each commit |
| mute | output | 1 | Output mute request |

## Verification
A wrong pending flag shows up in one of two ways at the ports. A stale word may surface as an `applied` pulse with an unexpected `active_word`, at the very next trigger. Or a zero crossing may produce no commit at all, visible on the edge after the trigger.

A wrong timer count moves the commit earlier or later than E+T+1. With small random timeouts this shows within a few dozen cycles.

A cycle-level reference model in the bench is compared on every cycle. Any divergence is therefore reported at the first edge where it reaches an output.

// File: rtl/zcd_pkg.sv
package zcd_pkg;
  localparam int ZCD_SET_W = 34;
  localparam int ZCD_TMR_W = 24;
  localparam logic [ZCD_SET_W-1:0] ZCD_POR_WORD = 34'h1_2345_6789;

  function automatic logic zcd_safe_point(input logic zc, input logic quiet,
                                          input logic expired);
    return zc | quiet | expired;
  endfunction
endpackage

// File: rtl/zcd_hold_slot.sv
module zcd_hold_slot #(
  parameter int SET_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] word_in,
  input  logic             take,
  output logic             pend_q,
  output logic [SET_W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      word_q <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      word_q <= word_in;
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

  AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pend_q && word_q == $past(word_in))); // R7
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !pend_q); // R9
endmodule

// File: rtl/zcd_wait_timer.sv
module zcd_wait_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);
  logic             run_q;
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= load_val;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

  AST_TMR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == $past(load_val))); // R5
  AST_TMR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !run_q); // R7
endmodule

// File: rtl/zcd_commit_gate.sv
module zcd_commit_gate
  import zcd_pkg::*;
#(
  parameter int SET_W = ZCD_SET_W,
  parameter int TMR_W = ZCD_TMR_W,
  parameter logic [SET_W-1:0] RESET_WORD = SET_W'(ZCD_POR_WORD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [SET_W-1:0] upd_word,
  input  logic             zc_pulse,
  input  logic             no_signal,
  input  logic             ce_fall,
  input  logic [TMR_W-1:0] tmo_cycles,
  input  logic             supply_low,
  output logic [SET_W-1:0] active_word,
  output logic             applied,
  output logic             mute
);
  logic             upd_fire;
  logic             pend_q;
  logic [SET_W-1:0] pend_word;
  logic             tmr_expired;
  logic             commit;
  logic             tmr_start;
  logic             tmr_stop;

  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid & upd_ready;
  assign commit    = pend_q & ~upd_fire &
                     zcd_safe_point(zc_pulse, no_signal, tmr_expired);
  assign tmr_start = ce_fall & (upd_fire | (pend_q & ~commit));
  assign tmr_stop  = commit | upd_fire;

  zcd_hold_slot #(.SET_W(SET_W)) slot_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (upd_fire),
    .word_in (upd_word),
    .take    (commit),
    .pend_q  (pend_q),
    .word_q  (pend_word)
  );

  zcd_wait_timer #(.TMR_W(TMR_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tmr_start),
    .stop     (tmr_stop),
    .load_val (tmo_cycles),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_word <= RESET_WORD;
      applied     <= 1'b0;
      mute        <= 1'b0;
    end else begin
      applied <= commit;
      mute    <= supply_low;
      if (commit) active_word <= pend_word;
    end
  end

  AST_APPLIED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    applied |=> !applied); // R9
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !applied |-> $stable(active_word)); // R6
  AST_EXPIRY_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired && !upd_valid) |=> applied); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (zc_pulse || no_signal)) |=> !applied); // R8
  AST_MUTE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> mute); // R10
endmodule

// File: tb/zcd_commit_gate_tb.sv
module zcd_commit_gate_tb_top;
  localparam int SW = 34;
  localparam int TW = 24;
  localparam logic [SW-1:0] POR = 34'h1_2345_6789;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 0, zc_pulse = 0, no_signal = 0, ce_fall = 0, supply_low = 0;
  logic [SW-1:0] upd_word = '0;
  logic [TW-1:0] tmo_cycles = '0;
  logic upd_ready, applied, mute;
  logic [SW-1:0] active_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [SW-1:0] m_active = POR, m_pword = '0;
  logic m_pend = 0, m_run = 0, m_applied = 0, m_mute = 0;
  logic [TW-1:0] m_cnt = '0;

  always #5 clk = ~clk;

  zcd_commit_gate dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_word(upd_word), .zc_pulse(zc_pulse), .no_signal(no_signal),
    .ce_fall(ce_fall), .tmo_cycles(tmo_cycles), .supply_low(supply_low),
    .active_word(active_word), .applied(applied), .mute(mute)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_step();
    logic fire, cmt, st;
    fire = upd_valid;
    cmt  = m_pend && !fire && (zc_pulse || no_signal || (m_run && m_cnt == 0));
    st   = ce_fall && (fire || (m_pend && !cmt));
    if (st) begin m_run = 1; m_cnt = tmo_cycles; end
    else if (cmt || fire) m_run = 0;
    else if (m_run && m_cnt != 0) m_cnt = m_cnt - 1;
    m_applied = cmt;
    if (cmt) m_active = m_pword;
    if (fire) begin m_pword = upd_word; m_pend = 1; end
    else if (cmt) m_pend = 0;
    m_mute = supply_low;
  endfunction

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic clr();
    upd_valid = 0; zc_pulse = 0; no_signal = 0; ce_fall = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] wa, wb, wc, wd, we;
    wa = 34'h0_AAAA_0001; wb = 34'h2_0BBB_0002; wc = 34'h3_CCCC_0003;
    wd = 34'h1_DDDD_0004; we = 34'h0_EEEE_0005;
    repeat (3) @(negedge clk);
    chk("R1 reset active", active_word, POR);
    chk("R1 reset applied", applied, 0);
    rst_n = 1;
    tick();
    chk("R1 post-reset mute", mute, 0);
    chk("R2 ready", upd_ready, 1);
    // R6: load without trigger
    upd_valid = 1; upd_word = wa; tick(); clr();
    repeat (4) tick();
    chk("R6 no trigger active", active_word, POR);
    chk("R6 no trigger applied", applied, 0);
    // R3: zero crossing commits
    zc_pulse = 1; tick(); clr();
    chk("R3 zc commit word", active_word, wa);
    chk("R3 zc applied", applied, 1);
    tick();
    chk("R9 applied one cycle", applied, 0);
    // R9: trigger with nothing pending
    zc_pulse = 1; tick(); clr();
    chk("R9 empty trigger applied", applied, 0);
    chk("R9 empty trigger active", active_word, wa);
    // R8 then R4
    upd_valid = 1; upd_word = wb; no_signal = 1; tick(); clr();
    chk("R8 load wins applied", applied, 0);
    chk("R8 load wins active", active_word, wa);
    no_signal = 1; tick(); clr();
    chk("R4 quiet commit", active_word, wb);
    // R5: timeout with T=5
    tmo_cycles = 5;
    upd_valid = 1; upd_word = wc; tick(); clr();
    ce_fall = 1; tick(); clr();
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R5 before expiry", active_word, wb);
    end
    tick();
    chk("R5 timeout commit", active_word, wc);
    chk("R5 timeout applied", applied, 1);
    // R7: replacement cancels timer
    upd_valid = 1; upd_word = wd; tick(); clr();
    ce_fall = 1; tick(); clr();
    tick(); tick();
    upd_valid = 1; upd_word = we; tick(); clr();
    repeat (10) tick();
    chk("R7 timer cancelled", active_word, wc);
    tmo_cycles = 0; ce_fall = 1; tick(); clr();
    tick();
    chk("R7 replaced word committed", active_word, we);
    // R10 mute
    supply_low = 1; tick();
    chk("R10 mute on", mute, 1);
    chk("R10 active unaffected", active_word, we);
    supply_low = 0; tick();
    chk("R10 mute off", mute, 0);
    // random phase against model
    void'($urandom(32'd1746));
    for (int n = 0; n < 4000; n++) begin
      upd_valid  = ($urandom % 100) < 10;
      upd_word   = {$urandom, $urandom};
      zc_pulse   = ($urandom % 100) < 5;
      no_signal  = ($urandom % 100) < 3;
      ce_fall    = ($urandom % 100) < 10;
      tmo_cycles = TW'($urandom % 16);
      if (($urandom % 100) < 5) supply_low = ~supply_low;
      tick();
      chk("R3/R4/R5 model active", active_word, m_active);
      chk("R9 model applied", applied, m_applied);
      chk("R10 model mute", mute, m_mute);
      chk("R2 ready random", upd_ready, 1);
    end
    clr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule